// File: doc/BRIEF.md
# Time-Multiplexed Hit Word Transmitter

This block sends one beam crossing's detector hit bits from a front-level trigger device to a second-level correlator over a fixed 32-pin bus. The hit vector is too wide for the pins, so the block runs on a clock four times faster than the beam reference. Each beam period therefore holds four fast cycles: one idle slot and three data slots. In the idle slot the block captures the hit vector and the event-valid flag. If the event was flagged, it then drives three consecutive slices of the held word. Each slice goes out with its own slot-marker pin, so the receiver can frame the data without a separate strobe.

The bus has 3 marker pins and 29 data lanes, so one period carries 87 payload bits. Payload positions above the hit width are sent as zero. A period without a flagged event leaves the bus low for all four slots. A synchronous reset returns the block to the idle slot with the bus low. The slot phase is counted from the release of that reset, which is aligned to the beam clock.

Top module: `hit_burst_tx`

## Requirements
- R1: After reset is released, fast cycles form repeating groups of four. The first clock edge of each group captures the inputs and is followed by an idle bus word. The next three edges present data slots 1, 2 and 3, in that order.
- R2: In the idle slot, all 32 bus bits are zero.
- R3: In data slot k (k = 1, 2, 3), marker bit tx_bus[k-1] is high and the other two marker bits tx_bus[2:0] are low.
- R4: In data slot k, tx_bus[31:3] carries bits [(k-1)*29 +: 29] of the captured payload, lowest indices in slot 1.
- R5: A burst is sent only if evt_valid was high at the capture edge. Otherwise all four bus words of that group are zero.
- R6: hit_in and evt_valid are ignored at the three non-capture edges. The burst carries the values captured at the capture edge.
- R7: The payload is the hit vector zero-extended to 87 bits. With 80 hit bits, payload bits 80..86 (tx_bus[31:25] in slot 3) are always zero.
- R8: A synchronous reset high at an edge drives the bus to zero after that edge and restarts the phase. The first edge with reset low is a capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the beam reference |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 80 | Hit vector for the current beam crossing |
| evt_valid | input | 1 | Event flag; a burst is sent when high at the capture edge |
| tx_bus | output | 32 | [2:0] one-hot slot markers, [31:3] data lanes |

## Verification
Two things happen on the same edge: the capture of the next event and the retirement of the previous burst's third slot. A wrong hold register would let new hits leak into slot 3. The bench runs bursts back to back with different hit patterns, so slot 3 must still show the old word while the capture edge loads the new one. The bench also asserts reset right after slot 1 has appeared. It then checks that the bus clears at once and that a fresh burst starts exactly one capture edge after release.

// File: rtl/hit_burst_tx_pkg.sv
package hit_burst_tx_pkg;
  // one-hot slot marker for a 1-based slot index, zero for the idle slot
  function automatic logic [7:0] slot_mark(input int unsigned slot);
    logic [7:0] m;
    m = '0;
    if (slot != 0 && slot <= 8) m[slot-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hbt_phase_ctr.sv
module hbt_phase_ctr #(
  parameter int N_DATA = 3,
  localparam int PH_W = $clog2(N_DATA + 1)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            cap_slot
);
  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (phase == PH_W'(N_DATA)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign cap_slot = (phase == '0);
endmodule

// File: rtl/hbt_hold_reg.sv
module hbt_hold_reg #(
  parameter int HIT_W   = 80,
  parameter int PAYLOAD = 87
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap_slot,
  input  logic [HIT_W-1:0]   hit_in,
  input  logic               evt_valid,
  output logic [PAYLOAD-1:0] held,
  output logic               armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      armed <= 1'b0;
    end else if (cap_slot) begin
      held  <= PAYLOAD'(hit_in);
      armed <= evt_valid;
    end
  end
endmodule

// File: rtl/hbt_slot_mux.sv
module hbt_slot_mux
  import hit_burst_tx_pkg::*;
#(
  parameter int N_DATA = 3,
  parameter int LANES  = 29,
  localparam int PH_W    = $clog2(N_DATA + 1),
  localparam int PAYLOAD = N_DATA * LANES,
  localparam int BUS_W   = N_DATA + LANES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PH_W-1:0]    phase,
  input  logic               armed,
  input  logic [PAYLOAD-1:0] held,
  output logic [BUS_W-1:0]   bus
);
  logic [LANES-1:0]  slice [N_DATA];
  logic [LANES-1:0]  sel_data;
  logic [N_DATA-1:0] sel_mark;

  for (genvar k = 0; k < N_DATA; k++) begin : g_slice
    assign slice[k] = held[k*LANES +: LANES];
  end

  always_comb begin
    sel_data = '0;
    sel_mark = '0;
    for (int k = 0; k < N_DATA; k++) begin
      if (phase == PH_W'(k + 1)) begin
        sel_data = slice[k];
        sel_mark = N_DATA'(slot_mark(k + 1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !armed) bus <= '0;
    else bus <= {sel_data, sel_mark};
  end
endmodule

// File: rtl/hit_burst_tx.sv
module hit_burst_tx #(
  parameter int HIT_W  = 80,
  parameter int N_DATA = 3,
  parameter int LANES  = 29,
  localparam int PH_W    = $clog2(N_DATA + 1),
  localparam int PAYLOAD = N_DATA * LANES,
  localparam int BUS_W   = N_DATA + LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [HIT_W-1:0] hit_in,
  input  logic             evt_valid,
  output logic [BUS_W-1:0] tx_bus
);
  logic [PH_W-1:0]    phase;
  logic               cap_slot;
  logic [PAYLOAD-1:0] held;
  logic               armed;

  hbt_phase_ctr #(.N_DATA(N_DATA)) u_phase (
    .clk(clk), .rst(rst), .phase(phase), .cap_slot(cap_slot)
  );

  hbt_hold_reg #(.HIT_W(HIT_W), .PAYLOAD(PAYLOAD)) u_hold (
    .clk(clk), .rst(rst), .cap_slot(cap_slot), .hit_in(hit_in),
    .evt_valid(evt_valid), .held(held), .armed(armed)
  );

  hbt_slot_mux #(.N_DATA(N_DATA), .LANES(LANES)) u_mux (
    .clk(clk), .rst(rst), .phase(phase), .armed(armed), .held(held),
    .bus(tx_bus)
  );
endmodule

// File: rtl/hit_burst_tx_chk.sv
module hit_burst_tx_chk #(
  parameter int N_DATA = 3,
  parameter int BUS_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_valid,
  input logic [BUS_W-1:0] tx_bus
);
  logic [N_DATA-1:0] mk;
  assign mk = tx_bus[N_DATA-1:0];

  p_marker_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mk));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (mk == '0) |-> (tx_bus == '0));

  p_flagged_start_r5: assert property (@(posedge clk) disable iff (rst)
    mk[0] |-> $past(evt_valid, 2));

  for (genvar k = 0; k + 1 < N_DATA; k++) begin : g_order
    p_slot_order_r1: assert property (@(posedge clk) disable iff (rst)
      mk[k] |=> mk[k+1]);
  end

  p_last_then_idle_r1: assert property (@(posedge clk) disable iff (rst)
    mk[N_DATA-1] |=> (tx_bus == '0));

  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (tx_bus == '0));
endmodule

bind hit_burst_tx hit_burst_tx_chk #(.N_DATA(N_DATA), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .tx_bus(tx_bus)
);

// File: tb/hit_burst_tx_bench.sv
`timescale 1ns/1ps
module hit_burst_tx_bench;
  localparam int HIT_W = 80;
  localparam int ND    = 3;
  localparam int LN    = 29;
  localparam int PL    = ND * LN;
  localparam int BW    = ND + LN;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [HIT_W-1:0] hit_in = '0;
  logic             evt_valid = 1'b0;
  logic [BW-1:0]    tx_bus;

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;

  logic [BW-1:0] exp_q [$];
  string         tag_q [$];

  always #2.5 clk = ~clk;

  hit_burst_tx u_hit_burst_tx (
    .clk(clk), .rst(rst), .hit_in(hit_in), .evt_valid(evt_valid), .tx_bus(tx_bus)
  );

  task automatic check(input string tag, input logic [BW-1:0] got, input logic [BW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [BW-1:0] slot_word(input logic [HIT_W-1:0] h, input int k);
    logic [PL-1:0] p;
    p = PL'(h);
    return {p[k*LN +: LN], ND'(1 << k)};
  endfunction

  function automatic logic [HIT_W-1:0] rnd_hit();
    return {$urandom, $urandom, $urandom};
  endfunction

  // monitor: samples 1 ns after each edge
  always @(posedge clk) begin
    #1;
    if (mon_en && exp_q.size() > 0) check(tag_q.pop_front(), tx_bus, exp_q.pop_front());
  end

  // driver: called at the negedge before a capture edge, returns at the next one
  task automatic run_period(input logic [HIT_W-1:0] h, input logic ev, input string tag);
    hit_in = h;
    evt_valid = ev;
    exp_q.push_back('0); tag_q.push_back("R1,R2 idle");
    for (int k = 0; k < ND; k++) begin
      exp_q.push_back(ev ? slot_word(h, k) : '0);
      tag_q.push_back(ev ? tag : "R5 unflagged");
    end
    for (int k = 0; k < ND; k++) begin
      @(negedge clk);
      hit_in = rnd_hit();          // R6: must not reach the bus
      evt_valid = $urandom_range(0, 1) == 1;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [HIT_W-1:0] a, b;
    repeat (3) @(negedge clk);
    check("R8 reset state", tx_bus, '0);
    rst = 1'b0;
    mon_en = 1'b1;
    run_period(rnd_hit(), 1'b1, "R3,R4 first burst");
    run_period(rnd_hit(), 1'b1, "R4,R6 back-to-back");
    run_period(rnd_hit(), 1'b0, "R5");
    run_period({HIT_W{1'b1}}, 1'b1, "R7 all-ones padding");
    run_period(HIT_W'(1), 1'b1, "R4 lowest bit");
    run_period({1'b1, {(HIT_W-1){1'b0}}}, 1'b1, "R7 top hit bit");
    for (int i = 0; i < 20; i++) run_period(rnd_hit(), ($urandom_range(0, 3) != 0), "R4,R6 random");
    mon_en = 1'b0;
    check("R1 scoreboard drained", BW'(exp_q.size()), '0);

    // reset in the middle of a burst
    a = rnd_hit();
    b = rnd_hit();
    hit_in = a; evt_valid = 1'b1;
    @(negedge clk);                        // capture edge passed
    check("R2 idle before burst", tx_bus, '0);
    @(negedge clk);
    check("R4 slot1 before reset", tx_bus, slot_word(a, 0));
    rst = 1'b1;
    @(negedge clk);
    check("R8 cleared by reset", tx_bus, '0);
    rst = 1'b0;
    hit_in = b; evt_valid = 1'b1;
    @(negedge clk);
    check("R8 first edge captures", tx_bus, '0);
    hit_in = rnd_hit(); evt_valid = 1'b0;
    @(negedge clk);
    check("R8 restart slot1", tx_bus, slot_word(b, 0));
    @(negedge clk);
    check("R8 restart slot2", tx_bus, slot_word(b, 1));
    @(negedge clk);
    check("R7 restart slot3", tx_bus, slot_word(b, 2));
    @(negedge clk);
    check("R1 back to idle", tx_bus, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule